// File: doc/BRIEF.md
# Register command sequence executor

This block takes fixed 64-byte command records, one at a time, from a valid/ready port. It decodes the header word of each record and turns it into a series of register-bus transactions. Four kinds of work are supported. A masked update touches a list of independent registers. A step chain applies several mask/value steps to one register. A streaming write pushes a list of words into one address, which suits table loading. A polled wait reads one register until a masked field matches or a microsecond budget runs out.

A host places a record on `cmdData`, raises `cmdValid` and waits for the one-cycle `cmdDone` pulse before it sends the next record. The register bus is a plain request/acknowledge master that has one transaction outstanding at a time. `usTick` is a one-cycle strobe that pulses once per microsecond. The polled wait uses it to measure how long it has been running.

Top module: `regseq_exec`

## Requirements
- R1: Word i of a record sits at `cmdData[32*i+31:32*i]`. Word 0 is the header: opcode in bits 7:0, payload byte count in bits 29:24, and the other bits are ignored. `cmdReady` is high only while idle. A record is taken when `cmdValid` and `cmdReady` are both high, and `cmdReady` stays low until the done pulse of that record.
- R2: Opcode 0 and any opcode above 4 finish with a done pulse and no bus transaction.
- R3: Opcode 1 (masked update) has floor(bytes/12) entries. Entry k uses word 1+3k as address, word 2+3k as mask and word 3+3k as value. The block reads the address, then writes (old & ~mask) | (value & mask). Entries run in order.
- R4: A masked-update entry whose mask is all ones issues no read. It writes the value as it is.
- R5: Opcode 2 (step chain) uses word 1 as address and has floor((bytes-4)/8) steps. Step k uses word 2+2k as mask and word 3+2k as value. The block does at most one read, before step 0 only, and only when the step-0 mask is not all ones. Every step writes the merge of its mask/value into the value written by the step before it.
- R6: Opcode 3 (streaming write) uses word 1 as address and has floor((bytes-4)/4) data words, starting at word 2. Each data word is written to that address in order, and no read is issued.
- R7: Opcode 4 (polled wait) uses word 1 as address, word 2 as mask, word 3 as expected value and word 4 as budget in microseconds. The block reads the address again and again. When (data & mask) equals the expected value, it finishes with `cmdTimeout` low.
- R8: The polled-wait budget counts `usTick` pulses seen since the record was accepted. If a read misses while that count is at least the budget, the command finishes with `cmdTimeout` high. A budget of 0 therefore gives exactly one read.
- R9: Leftover payload bytes that do not fill a whole entry are dropped. A count that yields zero entries (for example a step chain or streaming write with fewer than 4 bytes) finishes with no bus transaction.
- R10: While `busReq` is high without `busAck`, the request stays asserted with `busAddr`, `busWe` and `busWdata` unchanged in the next cycle.
- R11: `cmdDone` lasts exactly one cycle. `cmdTimeout` is high only in a done cycle of a polled wait.
- R12: After reset, `cmdReady` is 1 while `busReq` and `cmdDone` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| cmdValid | input | 1 | record offered |
| cmdReady | output | 1 | block is idle and takes a record |
| cmdData | input | 512 | 16-word command record |
| usTick | input | 1 | one pulse per microsecond |
| busReq | output | 1 | bus request, held until acknowledged |
| busWe | output | 1 | 1 write, 0 read |
| busAddr | output | 32 | register address |
| busWdata | output | 32 | write data |
| busRdata | input | 32 | read data, valid with acknowledge |
| busAck | input | 1 | transaction acknowledge |
| cmdDone | output | 1 | one-cycle end-of-record pulse |
| cmdTimeout | output | 1 | polled wait expired, valid with cmdDone |

## Verification
The bench targets places where a plausible mistake changes the bus trace. If the all-ones mask does not skip the read, an extra read appears in the masked update. If the step chain reads again between steps, it reads an auto-incrementing register several times, and if it merges against stale data, the write values are wrong. For the polled wait, the bench uses a register that only matches on the fourth read, which shows whether the block gives up early or polls past a match. A budget of zero must stop after one read with the timeout flag set. The bench also truncates byte counts and sends unknown opcodes, and a design that rounds up or fails to treat an unknown opcode as a no-op generates traffic that should not be there.

// File: rtl/regseq_pkg.sv
`timescale 1ns/1ps
package regseq_pkg;
  localparam int WORD_W    = 32;
  localparam int CMD_WORDS = 16;
  localparam int IDX_W     = 4;
  localparam int LEN_W     = 6;

  localparam logic [7:0] OP_NULL  = 8'd0;
  localparam logic [7:0] OP_RMW   = 8'd1;
  localparam logic [7:0] OP_FIELD = 8'd2;
  localparam logic [7:0] OP_BURST = 8'd3;
  localparam logic [7:0] OP_WAIT  = 8'd4;

  // control -> datapath
  typedef struct packed {
    logic loadCmd;
    logic captureRd;
    logic commitWr;
    logic nextIdx;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic isRmw;
    logic isField;
    logic isBurst;
    logic isWait;
    logic noEntries;
    logic firstEntry;
    logic lastEntry;
    logic needRead;
    logic pollHit;
    logic pollExpired;
  } seqStatus_t;
endpackage

// File: rtl/regseq_dp.sv
`timescale 1ns/1ps
module regseq_dp
  import regseq_pkg::*;
#(
  parameter int WordW    = WORD_W,
  parameter int CmdWords = CMD_WORDS,
  parameter int IdxW     = IDX_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strobe,
  input  logic [WordW*CmdWords-1:0] cmdData,
  input  logic                      usTick,
  input  logic [WordW-1:0]          busRdata,
  output logic [WordW-1:0]          busAddr,
  output logic [WordW-1:0]          busWdata,
  output seqStatus_t                status
);
  localparam int SelW = $clog2(CmdWords);
  localparam int LenW = LEN_W;
  localparam logic [WordW-1:0] AllOnes = '1;

  logic [CmdWords-1:0][WordW-1:0] wordsQ;
  logic [IdxW-1:0]                idxQ;
  logic [WordW-1:0]               workQ;
  logic [WordW-1:0]               elapsedQ;

  logic [7:0]      opc;
  logic [LenW-1:0] nBytes, bodyBytes, entryCount, idxWide;
  logic [WordW-1:0] curAddr, curMask, curVal, mergeVal;
  int idxI;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordsQ <= '0;
    else if (strobe.loadCmd) wordsQ <= cmdData;
  end

  assign opc       = wordsQ[0][7:0];
  assign nBytes    = wordsQ[0][29:24];
  assign bodyBytes = (nBytes >= LenW'(4)) ? nBytes - LenW'(4) : '0;

  always_comb begin
    case (opc)
      OP_RMW:   entryCount = nBytes / LenW'(12);
      OP_FIELD: entryCount = bodyBytes >> 3;
      OP_BURST: entryCount = bodyBytes >> 2;
      default:  entryCount = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxQ <= '0;
    else if (strobe.loadCmd) idxQ <= '0;
    else if (strobe.nextIdx) idxQ <= idxQ + 1'b1;
  end

  assign idxI    = int'(idxQ);
  assign idxWide = LenW'(idxQ);

  function automatic logic [WordW-1:0] wordAt(input int k);
    logic [SelW-1:0] sel;
    sel = k[SelW-1:0];
    return (k < CmdWords) ? wordsQ[sel] : '0;
  endfunction

  // operand selection per opcode and entry index
  always_comb begin
    curAddr = wordAt(1);
    curMask = AllOnes;
    curVal  = '0;
    case (opc)
      OP_RMW: begin
        curAddr = wordAt(1 + 3 * idxI);
        curMask = wordAt(2 + 3 * idxI);
        curVal  = wordAt(3 + 3 * idxI);
      end
      OP_FIELD: begin
        curMask = wordAt(2 + 2 * idxI);
        curVal  = wordAt(3 + 2 * idxI);
      end
      OP_BURST: curVal = wordAt(2 + idxI);
      OP_WAIT: begin
        curMask = wordAt(2);
        curVal  = wordAt(3);
      end
      default: ;
    endcase
  end

  assign mergeVal = (workQ & ~curMask) | (curVal & curMask);

  // working copy: last read data, then last written data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) workQ <= '0;
    else if (strobe.captureRd) workQ <= busRdata;
    else if (strobe.commitWr) workQ <= mergeVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) elapsedQ <= '0;
    else if (strobe.loadCmd) elapsedQ <= '0;
    else if (usTick && elapsedQ != AllOnes) elapsedQ <= elapsedQ + 1'b1;
  end

  assign busAddr  = curAddr;
  assign busWdata = mergeVal;

  assign status.isRmw       = (opc == OP_RMW);
  assign status.isField     = (opc == OP_FIELD);
  assign status.isBurst     = (opc == OP_BURST);
  assign status.isWait      = (opc == OP_WAIT);
  assign status.noEntries   = (entryCount == '0);
  assign status.firstEntry  = (idxQ == '0);
  assign status.lastEntry   = (idxWide + LenW'(1) == entryCount);
  assign status.needRead    = (curMask != AllOnes);
  assign status.pollHit     = ((busRdata & curMask) == curVal);
  assign status.pollExpired = (elapsedQ >= wordAt(4));

  // R9
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryCount == '0) ? (idxQ == '0) : (idxWide < entryCount));
endmodule

// File: rtl/regseq_ctrl.sv
`timescale 1ns/1ps
module regseq_ctrl
  import regseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       busAck,
  input  seqStatus_t status,
  output logic       cmdReady,
  output logic       cmdDone,
  output logic       cmdTimeout,
  output logic       busReq,
  output logic       busWe,
  output seqStrobe_t strobe
);
  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_STEP, S_READ, S_WRITE, S_POLL, S_FIN
  } seqState_e;

  seqState_e stateQ, stateD;
  logic tmoQ, tmoSet;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    tmoSet = 1'b0;
    case (stateQ)
      S_IDLE: if (cmdValid) begin
        strobe.loadCmd = 1'b1;
        stateD = S_DECODE;
      end
      S_DECODE: begin
        if (status.isWait) stateD = S_POLL;
        else if ((status.isRmw || status.isField || status.isBurst) && !status.noEntries)
          stateD = S_STEP;
        else stateD = S_FIN;
      end
      S_STEP: begin
        if (status.needRead && (status.isRmw || (status.isField && status.firstEntry)))
          stateD = S_READ;
        else stateD = S_WRITE;
      end
      S_READ: if (busAck) begin
        strobe.captureRd = 1'b1;
        stateD = S_WRITE;
      end
      S_WRITE: if (busAck) begin
        strobe.commitWr = 1'b1;
        if (status.lastEntry) stateD = S_FIN;
        else begin
          strobe.nextIdx = 1'b1;
          stateD = S_STEP;
        end
      end
      S_POLL: if (busAck) begin
        if (status.pollHit) stateD = S_FIN;
        else if (status.pollExpired) begin
          tmoSet = 1'b1;
          stateD = S_FIN;
        end
      end
      S_FIN:   stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      tmoQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobe.loadCmd) tmoQ <= 1'b0;
      else if (tmoSet) tmoQ <= 1'b1;
    end
  end

  assign cmdReady   = (stateQ == S_IDLE);
  assign cmdDone    = (stateQ == S_FIN);
  assign cmdTimeout = cmdDone && tmoQ;
  assign busReq     = (stateQ == S_READ) || (stateQ == S_WRITE) || (stateQ == S_POLL);
  assign busWe      = (stateQ == S_WRITE);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady |=> !cmdReady);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);
  // R11
  tmo_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdTimeout |-> status.isWait);
  // R6
  burst_noread_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWe |-> !status.isBurst);
  // R2
  null_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (status.isRmw || status.isField || status.isBurst || status.isWait));
endmodule

// File: rtl/regseq_exec.sv
`timescale 1ns/1ps
module regseq_exec
  import regseq_pkg::*;
#(
  parameter int WordW    = WORD_W,
  parameter int CmdWords = CMD_WORDS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdValid,
  output logic                      cmdReady,
  input  logic [WordW*CmdWords-1:0] cmdData,
  input  logic                      usTick,
  output logic                      busReq,
  output logic                      busWe,
  output logic [WordW-1:0]          busAddr,
  output logic [WordW-1:0]          busWdata,
  input  logic [WordW-1:0]          busRdata,
  input  logic                      busAck,
  output logic                      cmdDone,
  output logic                      cmdTimeout
);
  seqStrobe_t strobe;
  seqStatus_t status;

  regseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .busAck(busAck),
    .status(status), .cmdReady(cmdReady), .cmdDone(cmdDone),
    .cmdTimeout(cmdTimeout), .busReq(busReq), .busWe(busWe), .strobe(strobe)
  );

  regseq_dp #(.WordW(WordW), .CmdWords(CmdWords), .IdxW(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdData(cmdData),
    .usTick(usTick), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .status(status)
  );

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata));
endmodule

// File: tb/sim_regseq_exec.sv
`timescale 1ns/1ps
module sim_regseq_exec;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [511:0] cmdData = '0;
  logic usTick = 1'b0;
  logic busReq, busWe;
  logic [31:0] busAddr, busWdata;
  logic [31:0] busRdata = '0;
  logic busAck = 1'b0;
  logic cmdDone, cmdTimeout;

  regseq_exec u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdData(cmdData), .usTick(usTick), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .cmdDone(cmdDone), .cmdTimeout(cmdTimeout)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic [31:0] mem [0:15];
  logic [31:0] wrAddrLog [0:31];
  logic [31:0] wrDataLog [0:31];
  int wrN = 0, rdN = 0, waitCnt = 0, hits6 = 0, holdErr = 0;
  logic [511:0] cmdBuf;
  bit gotTmo, busyOk, doneDropped;
  int cycles;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus slave: variable latency, index 6 matches only from its 4th read
  initial forever begin
    @(negedge clk);
    if (busAck) busAck = 1'b0;
    else if (busReq) begin
      if (waitCnt < (rdN + wrN) % 3) waitCnt++;
      else begin
        waitCnt = 0;
        busAck = 1'b1;
        if (busWe) begin
          mem[busAddr[5:2]] = busWdata;
          if (wrN < 32) begin
            wrAddrLog[wrN] = busAddr;
            wrDataLog[wrN] = busWdata;
          end
          wrN++;
        end else begin
          busRdata = mem[busAddr[5:2]];
          rdN++;
          if (busAddr[5:2] == 4'd6) begin
            hits6++;
            if (hits6 == 3) mem[6] = 32'h0000_0C00;
          end
        end
      end
    end
  end

  // R10 hold monitor at the ports
  initial begin
    logic prevReq, prevAck, prevWe;
    logic [31:0] prevAddr, prevData;
    prevReq = 0; prevAck = 0; prevWe = 0; prevAddr = 0; prevData = 0;
    forever begin
      @(negedge clk);
      if (rstN && prevReq && !prevAck &&
          (!busReq || busAddr != prevAddr || busWe != prevWe || busWdata != prevData))
        holdErr++;
      prevReq = busReq; prevAck = busAck; prevWe = busWe;
      prevAddr = busAddr; prevData = busWdata;
    end
  end

  initial forever begin
    repeat (10) @(negedge clk);
    usTick = 1'b1;
    @(negedge clk);
    usTick = 1'b0;
  end

  function automatic logic [31:0] hdr(input logic [7:0] op, input int bytes);
    return {2'b11, 6'(bytes), 16'hA5A5, op};
  endfunction

  task automatic putW(input int i, input logic [31:0] v);
    cmdBuf[i*32 +: 32] = v;
  endtask

  task automatic runCmd();
    wrN = 0; rdN = 0;
    @(negedge clk);
    cmdData = cmdBuf;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    busyOk = 1; cycles = 1;
    while (!cmdDone && cycles < 5000) begin
      if (cmdReady) busyOk = 0;
      @(negedge clk);
      cycles++;
    end
    chk(cmdDone, "R1 done seen", cycles, 0);
    chk(busyOk, "R1 ready low while busy", 0, 1);
    gotTmo = cmdTimeout;
    @(negedge clk);
    doneDropped = !cmdDone;
    chk(cmdReady, "R1 ready back after done", cmdReady, 1);
  endtask

  task automatic testReset();
    chk(cmdReady == 1'b1, "R12 ready", cmdReady, 1);
    chk(busReq == 1'b0, "R12 busReq", busReq, 0);
    chk(cmdDone == 1'b0, "R12 done", cmdDone, 0);
  endtask

  task automatic testNull();
    cmdBuf = '0; cmdBuf[0 +: 32] = hdr(8'd0, 60); putW(1, 32'h4);
    runCmd();
    chk(wrN + rdN == 0, "R2 null opcode traffic", wrN + rdN, 0);
    cmdBuf[0 +: 32] = hdr(8'd9, 60);
    runCmd();
    chk(wrN + rdN == 0, "R2 unknown opcode traffic", wrN + rdN, 0);
  endtask

  task automatic testRmw();
    mem[1] = 32'h1234_5678; mem[2] = 32'h0;
    cmdBuf = '0; cmdBuf[0 +: 32] = hdr(8'd1, 24);
    putW(1, 32'h4); putW(2, 32'h0000_FF00); putW(3, 32'hFFFF_ABFF);
    putW(4, 32'h8); putW(5, 32'hFFFF_FFFF); putW(6, 32'hDEAD_BEEF);
    runCmd();
    chk(mem[1] == 32'h1234_AB78, "R3 merged value", mem[1], 32'h1234_AB78);
    chk(mem[2] == 32'hDEAD_BEEF, "R4 full-mask value", mem[2], 32'hDEAD_BEEF);
    chk(rdN == 1, "R4 read skipped for full mask", rdN, 1);
    chk(wrN == 2 && wrAddrLog[0] == 32'h4 && wrAddrLog[1] == 32'h8, "R3 entry order",
        wrAddrLog[0], 32'h4);
    chk(doneDropped, "R11 done one cycle", !doneDropped, 0);
    chk(!gotTmo, "R11 no timeout on update", gotTmo, 0);
  endtask

  task automatic testField();
    mem[3] = 32'hF0F0_0000;
    cmdBuf = '0; cmdBuf[0 +: 32] = hdr(8'd2, 28);
    putW(1, 32'hC);
    putW(2, 32'h0000_000F); putW(3, 32'h0000_0001);
    putW(4, 32'h0000_00F0); putW(5, 32'h0000_0020);
    putW(6, 32'h0000_0001); putW(7, 32'h0000_0000);
    runCmd();
    chk(rdN == 1, "R5 single read", rdN, 1);
    chk(wrN == 3, "R5 step count", wrN, 3);
    chk(wrDataLog[0] == 32'hF0F0_0001, "R5 step0", wrDataLog[0], 32'hF0F0_0001);
    chk(wrDataLog[1] == 32'hF0F0_0021, "R5 step1", wrDataLog[1], 32'hF0F0_0021);
    chk(wrDataLog[2] == 32'hF0F0_0020, "R5 step2", wrDataLog[2], 32'hF0F0_0020);
    mem[3] = 32'h5555_5555;
    cmdBuf = '0; cmdBuf[0 +: 32] = hdr(8'd2, 20);
    putW(1, 32'hC);
    putW(2, 32'hFFFF_FFFF); putW(3, 32'h1111_1111);
    putW(4, 32'h0000_FF00); putW(5, 32'h0000_2200);
    runCmd();
    chk(rdN == 0, "R5 no read with full first mask", rdN, 0);
    chk(wrDataLog[1] == 32'h1111_2211, "R5 chain merge", wrDataLog[1], 32'h1111_2211);
  endtask

  task automatic testBurst();
    cmdBuf = '0; cmdBuf[0 +: 32] = hdr(8'd3, 24);
    putW(1, 32'h10);
    for (int i = 0; i < 5; i++) putW(2 + i, 32'h100 + i);
    runCmd();
    chk(wrN == 5 && rdN == 0, "R6 write count and no reads", wrN, 5);
    for (int i = 0; i < 5; i++)
      chk(wrDataLog[i] == 32'h100 + i && wrAddrLog[i] == 32'h10, "R6 data order",
          wrDataLog[i], 32'h100 + i);
    cmdBuf[0 +: 32] = hdr(8'd3, 63);
    for (int i = 0; i < 14; i++) putW(2 + i, 32'h200 + i);
    runCmd();
    chk(wrN == 14 && mem[4] == 32'h20D, "R9 63 bytes gives 14 words", wrN, 14);
  endtask

  task automatic testCounts();
    cmdBuf = '0; cmdBuf[0 +: 32] = hdr(8'd1, 35);
    putW(1, 32'h20); putW(2, 32'hFFFF_FFFF); putW(3, 32'h1);
    putW(4, 32'h24); putW(5, 32'hFFFF_FFFF); putW(6, 32'h2);
    putW(7, 32'h28); putW(8, 32'hFFFF_FFFF); putW(9, 32'h3);
    runCmd();
    chk(wrN == 2, "R9 35 bytes gives 2 entries", wrN, 2);
    cmdBuf[0 +: 32] = hdr(8'd2, 3);
    runCmd();
    chk(wrN + rdN == 0, "R9 short step chain idle", wrN + rdN, 0);
  endtask

  task automatic testWait();
    mem[6] = 32'h0000_0300; hits6 = 0;
    cmdBuf = '0; cmdBuf[0 +: 32] = hdr(8'd4, 16);
    putW(1, 32'h18); putW(2, 32'h0000_0F00); putW(3, 32'h0000_0C00); putW(4, 1000);
    runCmd();
    chk(rdN == 4, "R7 poll until match", rdN, 4);
    chk(!gotTmo, "R7 no timeout on match", gotTmo, 0);
    mem[7] = 32'h0;
    cmdBuf = '0; cmdBuf[0 +: 32] = hdr(8'd4, 16);
    putW(1, 32'h1C); putW(2, 32'h1); putW(3, 32'h1); putW(4, 3);
    runCmd();
    chk(gotTmo, "R8 timeout flag", gotTmo, 1);
    chk(rdN >= 2 && cycles >= 20, "R8 kept polling for budget", rdN, 2);
    putW(4, 0);
    runCmd();
    chk(gotTmo && rdN == 1, "R8 zero budget single read", rdN, 1);
    chk(wrN == 0, "R7 wait writes nothing", wrN, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNull();
    testRmw();
    testField();
    testBurst();
    testCounts();
    testWait();
    chk(holdErr == 0, "R10 request held until ack", holdErr, 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      finished = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule